// File: doc/BRIEF.md
# Masked Vector Register Move Unit

This unit carries out one packed vector move per accepted operation, with 64-bit lanes at vector lengths of 128, 256 or 512 bits. It has three forms. A load writes memory data into a register. A register copy writes one register into another. A store produces memory data with per-byte write enables. Each operation gives the unit:

- the source data;
- the old contents of the destination register;
- a per-lane mask, with merge or zero behaviour;
- an encoding class, which decides what happens to the destination bits above the active length;
- a memory address;
- a 4-bit reserved specifier field.

The unit checks the address alignment and the reserved field. A faulting operation returns a fault flag instead of a write.

Operations enter on a valid/ready handshake. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented one cycle later on a registered output with `out_valid`. While `out_valid` is high and `out_ready` is low, the output holds all of its values and `in_ready` is low, so back-pressure stalls the producer. `in_ready` equals `!out_valid || out_ready`, which lets the unit accept a new operation every cycle when nothing stalls it. The surrounding pipeline applies `reg_we` to the register file and `byte_en` to the memory port. Fetch, full opcode decode and the memory system sit outside the unit.

Top module: `mvm_move_unit`

## Requirements
- R1: `vlen` code 0, 1 and 2 select 2, 4 and 8 active lanes (128, 256, 512 bits). Code 3 is invalid and raises `fault_undef`.
- R2: For loads and copies, an active lane whose mask bit is set takes the source lane. When masking is off, every active lane takes the source lane. Masking is on only when `enc_class` is 2 (masked class) and `mask_en` is 1. The lane mask is ignored in classes 0 and 1.
- R3: For loads and copies with masking on, an active lane whose mask bit is clear keeps the `old_data` lane when `zero_mode` is 0, and becomes all zeros when `zero_mode` is 1.
- R4: A store (`op_form` 1) keeps `reg_we` low. It drives `byte_en` as eight bits per lane, bits 8j to 8j+7 for lane j. A lane's bits are all high only when the lane is active and written, and all low otherwise. `zero_mode` has no effect on a store. `res_data` carries the source in active lanes and zeros above them.
- R5: For loads (`op_form` 0) and copies (`op_form` 2) in class 1 (extended) or class 2 (masked), every result bit above the active length is zero.
- R6: Class 0 (legacy) allows only `vlen` 0 and raises `fault_undef` for any other length. Its loads and copies keep `old_data` bits 511:128 unchanged in the result.
- R7: A load or store whose address is not a multiple of 16, 32 or 64 bytes, for `vlen` 0, 1 or 2, raises `fault_prot`. A copy never raises `fault_prot`.
- R8: In classes 1 and 2, `rsv_spec` must be 4'b1111, and any other value raises `fault_undef`. Class 0 ignores `rsv_spec`. `op_form` 3 and `enc_class` 3 also raise `fault_undef`.
- R9: A faulting result has `reg_we` low, `byte_en` zero and `res_data` zero. `fault_undef` takes priority, so the two fault flags are never high together.
- R10: An accepted operation appears with `out_valid` on the next cycle. While `out_valid` is high and `out_ready` low, the outputs stay stable and `in_ready` is low. With `out_ready` high, `in_ready` is high.
- R11: After reset, `out_valid`, `reg_we`, `byte_en` and both fault flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| op_form | input | 2 | 0 load, 1 store, 2 register copy, 3 invalid |
| enc_class | input | 2 | 0 legacy, 1 extended, 2 masked, 3 invalid |
| vlen | input | 2 | 0: 128 bits, 1: 256 bits, 2: 512 bits, 3 invalid |
| mask_en | input | 1 | Enable the per-lane mask (masked class only) |
| zero_mode | input | 1 | 1 zeroes unwritten register lanes, 0 merges them |
| lane_mask | input | MAX_LANES (8) | Per-lane write mask |
| rsv_spec | input | 4 | Reserved specifier field, must be all ones |
| addr | input | ADDR_W (16) | Memory operand byte address |
| src_data | input | DATA_W (512) | Source operand |
| old_data | input | DATA_W (512) | Prior destination register contents |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| res_data | output | DATA_W (512) | Result register or store data |
| reg_we | output | 1 | Register write enable |
| byte_en | output | DATA_W/8 (64) | Store byte enables |
| fault_prot | output | 1 | Alignment (protection) fault |
| fault_undef | output | 1 | Undefined-operation fault |

## Verification
The assertions check four things on every cycle. A result is never both a register write and a store. A fault never comes with a write or an enable. The two fault flags are never high together. Each lane's byte enables are all high or all low. They also check the handshake rules: an accepted operation shows up on the next cycle, and a stalled output holds steady. The lane contents need the bench's sweep to show them. The sweep runs over every form, class and length, with mask patterns, merge and zero modes, reserved-field values and alignments, and it compares each result with an arithmetic model. That covers which lanes take the source, which keep old data, which become zero, and what happens above the active length. Only the directed scenario shows that a held result is the right one and that no operation is lost across a stall.

// File: rtl/mvm_pkg.sv
package mvm_pkg;
  typedef enum logic [1:0] {
    FORM_LOAD  = 2'd0,
    FORM_STORE = 2'd1,
    FORM_COPY  = 2'd2,
    FORM_BAD   = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    CLS_LEGACY = 2'd0,
    CLS_EXT    = 2'd1,
    CLS_MASKED = 2'd2,
    CLS_BAD    = 2'd3
  } class_e;

  localparam logic [1:0] VLEN_BAD  = 2'd3;
  localparam logic [3:0] RSV_VALID = 4'b1111;
endpackage

// File: rtl/mvm_fault_chk.sv
module mvm_fault_chk
  import mvm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  form_e             form,
  input  class_e            cls,
  input  logic [1:0]        vlen,
  input  logic [3:0]        rsv_spec,
  input  logic [ADDR_W-1:0] addr,
  output logic              undef,
  output logic              prot
);
  localparam logic [ADDR_W-1:0] BASE_ALIGN = ADDR_W'(16);

  logic [ADDR_W-1:0] align_mask;
  logic              misaligned;

  always_comb begin
    align_mask = (BASE_ALIGN << vlen) - ADDR_W'(1);
    misaligned = |(addr & align_mask);
    undef = (form == FORM_BAD) || (cls == CLS_BAD) || (vlen == VLEN_BAD)
         || ((cls == CLS_LEGACY) && (vlen != 2'd0))
         || ((cls != CLS_LEGACY) && (rsv_spec != RSV_VALID));
    prot  = !undef && (form != FORM_COPY) && misaligned;
  end
endmodule

// File: rtl/mvm_lane_mux.sv
module mvm_lane_mux #(
  parameter int LANE_W = 64,
  localparam int LBE_W = LANE_W / 8
) (
  input  logic [LANE_W-1:0] src_lane,
  input  logic [LANE_W-1:0] old_lane,
  input  logic              active,
  input  logic              write,
  input  logic              zero_mode,
  input  logic              keep_upper,
  input  logic              is_store,
  input  logic              fault,
  output logic [LANE_W-1:0] res_lane,
  output logic [LBE_W-1:0]  be_lane
);
  always_comb begin
    res_lane = '0;
    be_lane  = '0;
    if (!fault) begin
      if (is_store) begin
        res_lane = active ? src_lane : '0;
        be_lane  = (active && write) ? '1 : '0;
      end else if (active) begin
        if (write)           res_lane = src_lane;
        else if (!zero_mode) res_lane = old_lane;
      end else if (keep_upper) begin
        res_lane = old_lane;
      end
    end
  end
endmodule

// File: rtl/mvm_move_unit.sv
module mvm_move_unit
  import mvm_pkg::*;
#(
  parameter int LANE_W    = 64,
  parameter int MAX_LANES = 8,
  parameter int ADDR_W    = 16,
  localparam int DATA_W   = LANE_W * MAX_LANES,
  localparam int BE_W     = DATA_W / 8,
  localparam int LBE_W    = LANE_W / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           op_form,
  input  logic [1:0]           enc_class,
  input  logic [1:0]           vlen,
  input  logic                 mask_en,
  input  logic                 zero_mode,
  input  logic [MAX_LANES-1:0] lane_mask,
  input  logic [3:0]           rsv_spec,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    src_data,
  input  logic [DATA_W-1:0]    old_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_W-1:0]    res_data,
  output logic                 reg_we,
  output logic [BE_W-1:0]      byte_en,
  output logic                 fault_prot,
  output logic                 fault_undef
);
  form_e  form;
  class_e cls;
  logic   undef_d, prot_d, fault_d, masking, keep_upper, is_store;
  logic [MAX_LANES-1:0] lane_act, lane_wr;
  logic [DATA_W-1:0]    res_d;
  logic [BE_W-1:0]      be_d;
  logic                 accept;

  assign form       = form_e'(op_form);
  assign cls        = class_e'(enc_class);
  assign masking    = (cls == CLS_MASKED) && mask_en;
  assign keep_upper = (cls == CLS_LEGACY);
  assign is_store   = (form == FORM_STORE);
  assign fault_d    = undef_d || prot_d;

  mvm_fault_chk #(.ADDR_W(ADDR_W)) u_fault (
    .form     (form),
    .cls      (cls),
    .vlen     (vlen),
    .rsv_spec (rsv_spec),
    .addr     (addr),
    .undef    (undef_d),
    .prot     (prot_d)
  );

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    assign lane_act[j] = (32'(j) < (32'd2 << vlen));
    assign lane_wr[j]  = lane_act[j] && (!masking || lane_mask[j]);

    mvm_lane_mux #(.LANE_W(LANE_W)) u_mux (
      .src_lane   (src_data[j*LANE_W +: LANE_W]),
      .old_lane   (old_data[j*LANE_W +: LANE_W]),
      .active     (lane_act[j]),
      .write      (lane_wr[j]),
      .zero_mode  (zero_mode),
      .keep_upper (keep_upper),
      .is_store   (is_store),
      .fault      (fault_d),
      .res_lane   (res_d[j*LANE_W +: LANE_W]),
      .be_lane    (be_d[j*LBE_W +: LBE_W])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      res_data    <= '0;
      reg_we      <= 1'b0;
      byte_en     <= '0;
      fault_prot  <= 1'b0;
      fault_undef <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      res_data    <= res_d;
      reg_we      <= !fault_d && !is_store;
      byte_en     <= be_d;
      fault_prot  <= prot_d;
      fault_undef <= undef_d;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/mvm_move_unit_chk.sv
module mvm_move_unit_chk #(
  parameter int DATA_W    = 512,
  parameter int MAX_LANES = 8,
  localparam int BE_W     = DATA_W / 8,
  localparam int LBE_W    = BE_W / MAX_LANES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] res_data,
  input logic              reg_we,
  input logic [BE_W-1:0]   byte_en,
  input logic              fault_prot,
  input logic              fault_undef
);
  AST_STORE_NOT_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && reg_we) |-> (byte_en == '0)); // R4

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (fault_prot || fault_undef)) |-> (!reg_we && byte_en == '0)); // R9

  AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_prot, fault_undef})); // R9

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_data) && $stable(byte_en)
                                   && $stable(reg_we) && $stable(fault_prot)
                                   && $stable(fault_undef))); // R10

  AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready); // R10

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_be
    AST_BE_LANE_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_en[j*LBE_W +: LBE_W] == '0) || (byte_en[j*LBE_W +: LBE_W] == '1)); // R4
  end
endmodule

bind mvm_move_unit mvm_move_unit_chk #(.DATA_W(DATA_W), .MAX_LANES(MAX_LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .res_data    (res_data),
  .reg_we      (reg_we),
  .byte_en     (byte_en),
  .fault_prot  (fault_prot),
  .fault_undef (fault_undef)
);

// File: tb/mvm_move_unit_bench.sv
`timescale 1ns/1ps
module mvm_move_unit_bench;
  localparam int LW = 64;
  localparam int NL = 8;
  localparam int DW = LW * NL;
  localparam int BW = DW / 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_ready;
  logic [1:0]    op_form = '0, enc_class = '0, vlen = '0;
  logic          mask_en = 1'b0, zero_mode = 1'b0;
  logic [NL-1:0] lane_mask = '0;
  logic [3:0]    rsv_spec = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] src_data = '0, old_data = '0;
  logic          out_valid, out_ready = 1'b1;
  logic [DW-1:0] res_data;
  logic          reg_we;
  logic [BW-1:0] byte_en;
  logic          fault_prot, fault_undef;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  mvm_move_unit u_mvm_move_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_form(op_form), .enc_class(enc_class), .vlen(vlen), .mask_en(mask_en),
    .zero_mode(zero_mode), .lane_mask(lane_mask), .rsv_spec(rsv_spec), .addr(addr),
    .src_data(src_data), .old_data(old_data), .out_valid(out_valid),
    .out_ready(out_ready), .res_data(res_data), .reg_we(reg_we), .byte_en(byte_en),
    .fault_prot(fault_prot), .fault_undef(fault_undef)
  );

  task automatic check(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  logic [DW-1:0] e_data;
  logic [BW-1:0] e_be;
  logic          e_we, e_prot, e_undef;

  task automatic model(input int f, input int c, input int vl, input bit me, input bit zm,
                       input logic [3:0] rs, input logic [AW-1:0] ad,
                       input logic [NL-1:0] mk, input logic [DW-1:0] s,
                       input logic [DW-1:0] o);
    int  lanes = 2 << vl;
    bit  masking = (c == 2) && me;
    e_undef = (f == 3) || (c == 3) || (vl == 3) || (c == 0 && vl != 0) || (c != 0 && rs != 4'hF);
    e_prot  = !e_undef && (f != 2) && ((int'(ad) % (16 << vl)) != 0);
    e_data = '0; e_be = '0; e_we = 1'b0;
    if (!(e_undef || e_prot)) begin
      e_we = (f != 1);
      for (int j = 0; j < NL; j++) begin
        bit act = (j < lanes);
        bit wr  = act && (!masking || mk[j]);
        if (f == 1) begin
          if (act) e_data[j*LW +: LW] = s[j*LW +: LW];
          if (wr)  e_be[j*8 +: 8] = 8'hFF;
        end else if (act) begin
          if (wr) e_data[j*LW +: LW] = s[j*LW +: LW];
          else if (!zm) e_data[j*LW +: LW] = o[j*LW +: LW];
        end else if (c == 0) begin
          e_data[j*LW +: LW] = o[j*LW +: LW];
        end
      end
    end
  endtask

  task automatic drive(input int f, input int c, input int vl, input bit me, input bit zm,
                       input logic [3:0] rs, input logic [AW-1:0] ad,
                       input logic [NL-1:0] mk, input logic [DW-1:0] s,
                       input logic [DW-1:0] o);
    op_form = 2'(f); enc_class = 2'(c); vlen = 2'(vl); mask_en = me; zero_mode = zm;
    rsv_spec = rs; addr = ad; lane_mask = mk; src_data = s; old_data = o;
    in_valid = 1'b1;
  endtask

  function automatic logic [DW-1:0] pat(input logic [31:0] tagv, input int n);
    logic [DW-1:0] v;
    for (int j = 0; j < NL; j++) v[j*LW +: LW] = {tagv | 32'(j), 32'(n) ^ 32'h9E37_0000};
    return v;
  endfunction

  task automatic compare_all();
    check("R2 R3 R5 R6", "res_data", res_data, e_data);
    check("R4", "byte_en", DW'(byte_en), DW'(e_be));
    check("R4 R9", "reg_we", DW'(reg_we), DW'(e_we));
    check("R7 R9", "fault_prot", DW'(fault_prot), DW'(e_prot));
    check("R1 R6 R8", "fault_undef", DW'(fault_undef), DW'(e_undef));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [AW-1:0] addrs [3];
    logic [NL-1:0] masks [4];
    logic [DW-1:0] sA, oA, sB, oB, dA;
    int n = 0;
    addrs[0] = 16'h0400; addrs[1] = 16'h0408; addrs[2] = 16'h0410;
    masks[0] = 8'hA5; masks[1] = 8'h00; masks[2] = 8'hFF; masks[3] = 8'h3C;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check("R11", "out_valid", DW'(out_valid), '0);
    check("R11", "reg_we/byte_en/faults", DW'({reg_we, byte_en, fault_prot, fault_undef}), '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int f = 0; f < 3; f++)
      for (int c = 0; c < 3; c++)
        for (int vl = 0; vl < 4; vl++)
          for (int me = 0; me < 2; me++)
            for (int zm = 0; zm < 2; zm++)
              for (int rsel = 0; rsel < 2; rsel++)
                for (int ai = 0; ai < 3; ai++)
                  for (int mi = 0; mi < 4; mi++) begin
                    logic [3:0] rs = rsel ? 4'b0111 : 4'hF;
                    logic [DW-1:0] s = pat(32'hC0DE_0000, n);
                    logic [DW-1:0] o = pat(32'h0BAD_0000, n + 7);
                    drive(f, c, vl, me[0], zm[0], rs, addrs[ai], masks[mi], s, o);
                    model(f, c, vl, me[0], zm[0], rs, addrs[ai], masks[mi], s, o);
                    @(posedge clk); @(negedge clk);
                    check("R10", "out_valid after accept", DW'(out_valid), DW'(1));
                    compare_all();
                    n++;
                  end

    // R8: invalid form and class codes
    sA = pat(32'h1111_0000, 1); oA = pat(32'h2222_0000, 2);
    drive(3, 1, 0, 0, 0, 4'hF, 16'h0400, 8'hFF, sA, oA);
    model(3, 1, 0, 0, 0, 4'hF, 16'h0400, 8'hFF, sA, oA);
    @(posedge clk); @(negedge clk); compare_all();
    drive(0, 3, 0, 0, 0, 4'hF, 16'h0400, 8'hFF, sA, oA);
    model(0, 3, 0, 0, 0, 4'hF, 16'h0400, 8'hFF, sA, oA);
    @(posedge clk); @(negedge clk); compare_all();

    // R10: back-pressure holds result A and stalls B
    sA = pat(32'hAAAA_0000, 3); oA = pat(32'h5555_0000, 4);
    sB = pat(32'hBBBB_0000, 5); oB = pat(32'h6666_0000, 6);
    drive(2, 2, 2, 1, 1, 4'hF, 16'h0000, 8'h0F, sA, oA);
    model(2, 2, 2, 1, 1, 4'hF, 16'h0000, 8'h0F, sA, oA);
    dA = e_data;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
    drive(0, 1, 1, 0, 0, 4'hF, 16'h0020, 8'h00, sB, oB);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "in_ready while stalled", DW'(in_ready), '0);
    check("R10", "out_valid while stalled", DW'(out_valid), DW'(1));
    check("R10", "held res_data", res_data, dA);
    out_ready = 1'b1;
    model(0, 1, 1, 0, 0, 4'hF, 16'h0020, 8'h00, sB, oB);
    @(posedge clk); @(negedge clk);
    check("R10", "in_ready released", DW'(in_ready), DW'(1));
    compare_all();
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10", "out_valid drains", DW'(out_valid), '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule